// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds a word-addressed memory that several hardware contexts share, and it keeps one reservation register for each context. Accesses arrive on a single request port, one per cycle. Each request carries an operation code, the issuing context, a word address and write data. A load-linked returns the word and records the address as that context's reservation. A later store-conditional from the same context writes the word only if the reservation is still valid and names the same address. It reports a pass/fail code either way.

A plain write from any context clears every reservation on the address it writes. A successful conditional store does the same to the other contexts' reservations. A per-context switch pulse cancels that context's reservation. Every response, including its data and conditional-store code, appears exactly one cycle after the request is accepted.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `rsp_valid` is low, no context holds a reservation, so a store-conditional fails, and every memory word reads as zero.
- R2: The operation code is 0 = read, 1 = write, 2 = load-linked, 3 = store-conditional. Every accepted request gives `rsp_valid` high in the next cycle only, and for a read or a load-linked `rsp_rdata` then carries the addressed word.
- R3: A store-conditional from a context whose valid reservation names the same address writes the word and returns `rsp_sc_fail` = 0.
- R4: A failing store-conditional returns `rsp_sc_fail` = 1 and leaves the memory unchanged.
- R5: A store-conditional to an address other than the reserved one fails.
- R6: Every store-conditional clears the issuing context's reservation, whether it passes or fails. A second store-conditional with no load-linked between the two fails.
- R7: A new load-linked replaces the context's earlier reservation. Only the latest address can then succeed.
- R8: A plain write by any context clears every reservation on the written address and leaves reservations on other addresses intact.
- R9: A successful store-conditional clears the matching reservations of all other contexts in the same cycle. Reservations on other addresses survive.
- R10: A pulse on `ctx_switch[c]` clears only context c's reservation.
- R11: A switch pulse for the issuing context in the same cycle as its store-conditional makes the store fail. A switch pulse in the same cycle as its load-linked leaves no reservation, although the data is still returned.
- R12: A plain write stores its data, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_ctx | input | CTX_W | Issuing context |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data for write and store-conditional |
| ctx_switch | input | NUM_CTX | Per-context switch pulse, clears that reservation |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data for read and load-linked |
| rsp_sc_fail | output | 1 | 1 when a store-conditional failed, else 0 |

## Verification
A context-switch pulse can fall in the same cycle as a store-conditional or a load-linked from the same context. The bench provokes both collisions. It raises `ctx_switch` for the issuing context on the exact cycle of the request. For the store it expects a fail code and an unchanged word on a later read. For the load-linked it expects the data to be returned and a following store-conditional to fail. The bench also checks that a switch aimed at another context leaves an unrelated context's conditional store able to pass.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_LL    = 2'd2,
      OP_SC    = 2'd3
   } llsc_op_e;
endpackage

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [ADDR_W-1:0] set_addr_i,
   input  logic              clr_own_i,
   input  logic              kill_i,
   input  logic              snoop_i,
   input  logic [ADDR_W-1:0] snoop_addr_i,
   output logic              rsv_valid_o,
   output logic [ADDR_W-1:0] rsv_addr_o
);
   logic              valid_q;
   logic [ADDR_W-1:0] addr_q;
   logic              snoop_hit;

   assign snoop_hit = snoop_i && valid_q && (addr_q == snoop_addr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else if (kill_i) begin
         valid_q <= 1'b0;
      end else if (set_i) begin
         valid_q <= 1'b1;
         addr_q  <= set_addr_i;
      end else if (clr_own_i || snoop_hit) begin
         valid_q <= 1'b0;
      end
   end

   assign rsv_valid_o = valid_q;
   assign rsv_addr_o  = addr_q;

   // R10
   switch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_i |=> !rsv_valid_o);
   // R7
   ll_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !kill_i) |=> (rsv_valid_o && rsv_addr_o == $past(set_addr_i)));
   // R6
   sc_drops_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_own_i && !set_i) |=> !rsv_valid_o);
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter bit MEM_RESET = 1'b1,
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   generate
      if (MEM_RESET) begin : g_rst_mem
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we_i) begin
               mem[addr_i] <= wdata_i;
            end
         end
      end else begin : g_plain_mem
         always_ff @(posedge clk) begin
            if (we_i) mem[addr_i] <= wdata_i;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata_q <= '0;
      else if (re_i) rdata_q <= mem[addr_i];
   end

   assign rdata_o = rdata_q;

   // R12
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/llsc_rsp_stage.sv
module llsc_rsp_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic sc_fail_i,
   output logic rsp_valid_o,
   output logic rsp_fail_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_fail_o  <= 1'b0;
      end else begin
         rsp_valid_o <= req_i;
         rsp_fail_o  <= req_i && sc_fail_i;
      end
   end

   // R2
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> rsp_valid_o);
   // R2
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !rsp_valid_o);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int  NUM_CTX   = 4,
   parameter int  ADDR_W    = 6,
   parameter int  DATA_W    = 16,
   parameter bit  MEM_RESET = 1'b1,
   localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [CTX_W-1:0]   req_ctx,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [NUM_CTX-1:0] ctx_switch,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               rsp_sc_fail
);
   generate
      if (NUM_CTX < 2)  begin : g_bad_ctx  $error("NUM_CTX must be at least 2"); end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr $error("ADDR_W out of range"); end
      if (DATA_W < 1)   begin : g_bad_data $error("DATA_W must be positive"); end
   endgenerate

   llsc_op_e          op;
   logic              ctx_ok;
   logic              is_rd, is_wr, is_ll, is_sc;
   logic              own_valid, own_switch, sc_ok, mem_we;
   logic [ADDR_W-1:0] own_addr;
   logic [NUM_CTX-1:0]              rsv_valid;
   logic [NUM_CTX-1:0][ADDR_W-1:0]  rsv_addr;

   assign op     = llsc_op_e'(req_op);
   assign ctx_ok = (32'(req_ctx) < NUM_CTX);
   assign is_rd  = req_valid && (op == OP_READ);
   assign is_wr  = req_valid && (op == OP_WRITE);
   assign is_ll  = req_valid && ctx_ok && (op == OP_LL);
   assign is_sc  = req_valid && (op == OP_SC);

   always_comb begin
      own_valid  = 1'b0;
      own_addr   = '0;
      own_switch = 1'b0;
      for (int c = 0; c < NUM_CTX; c++) begin
         if (32'(req_ctx) == c) begin
            own_valid  = rsv_valid[c];
            own_addr   = rsv_addr[c];
            own_switch = ctx_switch[c];
         end
      end
   end

   assign sc_ok  = is_sc && own_valid && !own_switch && (own_addr == req_addr);
   assign mem_we = is_wr || sc_ok;

   generate
      for (genvar c = 0; c < NUM_CTX; c++) begin : g_slot
         llsc_rsv_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .set_i        (is_ll && (32'(req_ctx) == c)),
            .set_addr_i   (req_addr),
            .clr_own_i    (is_sc && (32'(req_ctx) == c)),
            .kill_i       (ctx_switch[c]),
            .snoop_i      (mem_we),
            .snoop_addr_i (req_addr),
            .rsv_valid_o  (rsv_valid[c]),
            .rsv_addr_o   (rsv_addr[c])
         );
      end
   endgenerate

   llsc_word_mem #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_RESET(MEM_RESET)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .re_i    (is_rd || (req_valid && op == OP_LL)),
      .addr_i  (req_addr),
      .wdata_i (req_wdata),
      .rdata_o (rsp_rdata)
   );

   llsc_rsp_stage u_rsp (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_valid),
      .sc_fail_i   (is_sc && !sc_ok),
      .rsp_valid_o (rsp_valid),
      .rsp_fail_o  (rsp_sc_fail)
   );

   // Checker state: the last committed write and the reservations still naming it.
   logic              we_q;
   logic [ADDR_W-1:0] we_addr_q;
   logic [NUM_CTX-1:0] stale_hits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q      <= 1'b0;
         we_addr_q <= '0;
      end else begin
         we_q      <= mem_we;
         we_addr_q <= req_addr;
      end
   end

   always_comb begin
      for (int c = 0; c < NUM_CTX; c++)
         stale_hits[c] = rsv_valid[c] && (rsv_addr[c] == we_addr_q);
   end

   // R8 R9
   write_kills_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> (stale_hits == '0));
   // R4
   fail_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sc && !own_valid) |-> !mem_we);
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
   localparam int NC = 4;
   localparam int AW = 6;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic [1:0]    req_ctx = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [NC-1:0] ctx_switch = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_sc_fail;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit          chk_fail;
      bit          exp_fail;
      bit          chk_data;
      logic [DW-1:0] exp_data;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   llsc_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_ctx(req_ctx), .req_addr(req_addr), .req_wdata(req_wdata),
      .ctx_switch(ctx_switch), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_sc_fail(rsp_sc_fail)
   );

   task automatic issue(input logic [1:0] op, input int ctx, input int addr,
                        input int wd, input logic [NC-1:0] sw, input bit cf,
                        input bit ef, input bit cd, input int ed, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid  = 1'b1;
      req_op     = op;
      req_ctx    = 2'(ctx);
      req_addr   = AW'(addr);
      req_wdata  = DW'(wd);
      ctx_switch = sw;
      e.chk_fail = cf; e.exp_fail = ef; e.chk_data = cd; e.exp_data = DW'(ed); e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input logic [NC-1:0] sw);
      @(negedge clk);
      req_valid  = 1'b0;
      ctx_switch = sw;
   endtask

   task automatic rd(input int ctx, input int a, input int ed, input string tag);
      issue(2'd0, ctx, a, 0, '0, 0, 0, 1, ed, tag);
   endtask
   task automatic wr(input int ctx, input int a, input int wd);
      issue(2'd1, ctx, a, wd, '0, 0, 0, 0, 0, "R12");
   endtask
   task automatic ll(input int ctx, input int a, input int ed, input string tag);
      issue(2'd2, ctx, a, 0, '0, 0, 0, 1, ed, tag);
   endtask
   task automatic sc(input int ctx, input int a, input int wd, input bit ef, input string tag);
      issue(2'd3, ctx, a, wd, '0, 1, ef, 0, 0, tag);
   endtask

   // Monitor: pops one expected item per response.
   always @(negedge clk) begin
      if (rst_n && !done && rsp_valid) begin
         if (sb.size() == 0) begin
            checks++; failures++;
            $display("FAIL R2 unexpected response: actual rsp_valid=1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.chk_fail) begin
               checks++;
               if (rsp_sc_fail !== e.exp_fail) begin
                  failures++;
                  $display("FAIL %s sc code: actual %0b expected %0b", e.tag, rsp_sc_fail, e.exp_fail);
               end
            end
            if (e.chk_data) begin
               checks++;
               if (rsp_rdata !== e.exp_data) begin
                  failures++;
                  $display("FAIL %s data: actual %h expected %h", e.tag, rsp_rdata, e.exp_data);
               end
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         failures++;
         $display("FAIL R1 rsp_valid after reset: actual %b expected 0", rsp_valid);
      end
      // R1: no reservation after reset, memory zero
      sc(0, 5, 16'hDEAD, 1, "R1");
      rd(0, 5, 16'h0000, "R1");
      // R12 / R2: plain write then read
      wr(1, 5, 16'h1111);
      rd(2, 5, 16'h1111, "R12");
      // R3: LL then matching SC passes
      ll(0, 5, 16'h1111, "R2");
      sc(0, 5, 16'h2222, 0, "R3");
      rd(0, 5, 16'h2222, "R3");
      // R6: repeated SC fails; R4: memory unchanged
      sc(0, 5, 16'h3333, 1, "R6");
      rd(0, 5, 16'h2222, "R4");
      // R5: mismatched address
      ll(0, 5, 16'h2222, "R2");
      sc(0, 6, 16'h4444, 1, "R5");
      rd(0, 6, 16'h0000, "R4");
      sc(0, 5, 16'h4444, 1, "R6");
      // R7: newer LL replaces the older one
      ll(1, 7, 0, "R7");
      ll(1, 8, 0, "R7");
      sc(1, 7, 16'h0055, 1, "R7");
      ll(1, 7, 0, "R7");
      ll(1, 8, 0, "R7");
      sc(1, 8, 16'h0055, 0, "R7");
      rd(1, 8, 16'h0055, "R7");
      // R8: write elsewhere harmless, write to reserved address kills
      ll(2, 9, 0, "R8");
      wr(3, 10, 16'h0101);
      sc(2, 9, 16'h0099, 0, "R8");
      ll(2, 9, 16'h0099, "R8");
      wr(3, 9, 16'h0077);
      sc(2, 9, 16'h00AA, 1, "R8");
      rd(2, 9, 16'h0077, "R8");
      // R9: successful SC clears others on the same address only
      ll(0, 3, 0, "R9");
      ll(1, 3, 0, "R9");
      ll(2, 4, 0, "R9");
      sc(0, 3, 16'h0033, 0, "R9");
      sc(1, 3, 16'h00BB, 1, "R9");
      sc(2, 4, 16'h0044, 0, "R9");
      rd(3, 3, 16'h0033, "R9");
      // R10: switch clears only its own context
      ll(0, 12, 0, "R10");
      ll(1, 12, 0, "R10");
      idle(4'b0001);
      sc(0, 12, 16'h0C0C, 1, "R10");
      sc(1, 12, 16'h0D0D, 0, "R10");
      // R11: switch in the same cycle as SC and as LL
      ll(2, 13, 0, "R11");
      issue(2'd3, 2, 13, 16'h0E0E, 4'b0100, 1, 1, 0, 0, "R11");
      rd(2, 13, 16'h0000, "R11");
      issue(2'd2, 3, 14, 0, 4'b1000, 0, 0, 1, 16'h0000, "R11");
      sc(3, 14, 16'h0F0F, 1, "R11");
      idle('0);
      repeat (3) idle('0);
      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL R2 missing responses: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule